// File: doc/BRIEF.md
# Chained Descriptor DMA Engine

This block moves sector data between system memory and a card data FIFO without processor involvement per word. Software builds a list of four-word descriptors in memory, hands each one to the engine by setting its ownership bit, loads the list start address and then writes a poll-demand register. The engine fetches each descriptor and streams the described buffer either from memory into the card FIFO (towards the card) or from the FIFO into memory (from the card). It then writes the control word back with ownership returned to software and follows the list to the next descriptor.

Descriptor layout, at byte offsets from the descriptor address: +0 control, +4 buffer size in bytes (bits 11:0, a multiple of four), +8 buffer address, +12 next-descriptor address. The control word bits the engine acts on are: 31 owned by engine, 30 card error (written back), 5 end of ring, 4 chained, 3 first segment (carried through unchanged), 2 last segment, 1 completion interrupt suppressed. Register map (2-bit word address): 0 mode (bit 0 soft reset, self-clearing; bit 1 enable; bit 2 direction, 1 = memory to card), 1 list base address, 2 poll demand (any data), 3 status, write one to clear (bit 0 to-card done, bit 1 from-card done, bit 2 summary, bit 3 no descriptor available). The memory port holds a request until it sees a one-cycle acknowledge, with read data valid in the acknowledge cycle.

Top module: `chain_dma`

## Requirements
- R1: After reset the status output is zero and the engine makes no memory request, FIFO push or FIFO pop.
- R2: A write to the base register (address 1) loads the current descriptor pointer; a poll-demand write (address 2) while enabled fetches the four words of the descriptor at that pointer (+0, +4, +8, +12).
- R3: A fetched control word with bit 31 clear stops the engine without moving data and sets status bit 3; the next poll-demand write clears status bit 3.
- R4: In the to-card direction (mode bit 2 = 1) the engine reads size/4 words from the buffer address upward and pushes them into the FIFO in address order, never while fifo_full_i is high.
- R5: In the from-card direction (mode bit 2 = 0) the engine pops size/4 words, only while fifo_empty_i is low, and writes them to the buffer address upward in pop order.
- R6: After a descriptor's data, its control word is written back at +0 with bit 31 cleared and the other bits kept, with bit 30 set if card_err_i was high during that descriptor's data phase.
- R7: A written-back descriptor with control bit 1 clear sets status bit 0 (to card) or bit 1 (from card) together with summary bit 2; with bit 1 set no status bit changes.
- R8: The next pointer is the base address when control bit 5 is set, else word 3 when bit 4 is set, else the current pointer plus 16.
- R9: After a descriptor with control bit 2 set the engine stops; otherwise it fetches the next descriptor at once.
- R10: Writing ones to the status register (address 3) clears exactly those status bits.
- R11: Writing mode bit 0 abandons any descriptor in progress at once, with no further FIFO or memory traffic and no write-back, and reloads the pointer from the base register.
- R12: With mode bit 1 clear a poll-demand write starts nothing, and clearing it mid-descriptor lets that descriptor finish and write back but fetches no further one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| sts_o | output | 4 | Status bits: to-card done, from-card done, summary, no descriptor |
| mem_req_o | output | 1 | Memory access request, held until acknowledge |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 32 | Memory byte address, word aligned |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory access accepted, one cycle |
| mem_rdata_i | input | 32 | Memory read data, valid with acknowledge |
| fifo_push_o | output | 1 | Push one word into the card FIFO |
| fifo_wdata_o | output | 32 | Word pushed into the card FIFO |
| fifo_full_i | input | 1 | Card FIFO cannot accept a word |
| fifo_pop_o | output | 1 | Pop one word from the card FIFO |
| fifo_rdata_i | input | 32 | Head word of the card FIFO |
| fifo_empty_i | input | 1 | Card FIFO holds no word |
| card_err_i | input | 1 | Card-side error indication |

## Verification
The in-line assertions watch, on every cycle, that a soft reset silences both the memory port and the FIFO in the following cycle, that an ownership miss drops the memory request, that FIFO pushes and pops are separated by a memory access, that every completion pulse lands in the summary bit, and that poll demand clears the no-descriptor bit. What only the directed scenarios can show is the content of the traffic: word order across a chained pair, write-back values with and without the error bit, the wrap to the base on end of ring ahead of word 3, the stop on the last segment, and that an abandoned descriptor stays owned by the engine and is redone from the base on the next poll.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;
  localparam int DATA_W = 32;
  localparam int STS_W  = 4;

  // control word bit positions
  localparam int C_OWN   = 31;
  localparam int C_ERR   = 30;
  localparam int C_RING  = 5;
  localparam int C_CHAIN = 4;
  localparam int C_LAST  = 2;
  localparam int C_NOIRQ = 1;

  // register word addresses
  localparam logic [1:0] RA_MODE = 2'd0;
  localparam logic [1:0] RA_BASE = 2'd1;
  localparam logic [1:0] RA_POLL = 2'd2;
  localparam logic [1:0] RA_STAT = 2'd3;

  // mode register bits
  localparam int M_SWR = 0;
  localparam int M_EN  = 1;
  localparam int M_DIR = 2;

  // status bits
  localparam int S_TX  = 0;
  localparam int S_RX  = 1;
  localparam int S_SUM = 2;
  localparam int S_NOD = 3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_D0, ST_D1, ST_D2, ST_D3, ST_RD, ST_PUSH, ST_POP, ST_WR, ST_WB
  } eng_state_e;
endpackage

// File: rtl/chain_dma_regs.sv
module chain_dma_regs
  import chain_dma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              set_tx_i,
  input  logic              set_rx_i,
  input  logic              set_nod_i,
  output logic              enable_o,
  output logic              to_card_o,
  output logic [DATA_W-1:0] base_o,
  output logic              load_o,
  output logic              poll_o,
  output logic              swr_o,
  output logic [STS_W-1:0]  sts_o
);
  logic [STS_W-1:0] sts_q, sts_d;

  assign poll_o = reg_we_i && (reg_addr_i == RA_POLL);
  assign swr_o  = reg_we_i && (reg_addr_i == RA_MODE) && reg_wdata_i[M_SWR];
  assign sts_o  = sts_q;

  always_comb begin
    sts_d = sts_q;
    if (reg_we_i && reg_addr_i == RA_STAT) sts_d = sts_d & ~reg_wdata_i[STS_W-1:0];
    if (poll_o) sts_d[S_NOD] = 1'b0;
    if (set_tx_i) sts_d[S_TX] = 1'b1;
    if (set_rx_i) sts_d[S_RX] = 1'b1;
    if (set_tx_i || set_rx_i) sts_d[S_SUM] = 1'b1;
    if (set_nod_i) sts_d[S_NOD] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_o  <= 1'b0;
      to_card_o <= 1'b0;
      base_o    <= '0;
      load_o    <= 1'b0;
      sts_q     <= '0;
    end else begin
      sts_q  <= sts_d;
      load_o <= reg_we_i && (reg_addr_i == RA_BASE);
      if (reg_we_i && reg_addr_i == RA_MODE) begin
        enable_o  <= reg_wdata_i[M_EN];
        to_card_o <= reg_wdata_i[M_DIR];
      end
      if (reg_we_i && reg_addr_i == RA_BASE) base_o <= reg_wdata_i;
    end
  end

  assert_summary_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_tx_i || set_rx_i) |=> sts_q[S_SUM]);
  assert_poll_clears_nod_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_o && !set_nod_i) |=> !sts_q[S_NOD]);
endmodule

// File: rtl/chain_dma_next_ptr.sv
module chain_dma_next_ptr
  import chain_dma_pkg::*;
(
  input  logic [DATA_W-1:0] cur_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic [DATA_W-1:0] link_i,
  input  logic              ring_end_i,
  input  logic              chained_i,
  output logic [DATA_W-1:0] next_o
);
  localparam logic [DATA_W-1:0] DESC_BYTES = DATA_W'(16);

  // end of ring takes priority over the chain link
  always_comb begin
    if (ring_end_i)     next_o = base_i;
    else if (chained_i) next_o = link_i;
    else                next_o = cur_i + DESC_BYTES;
  end
endmodule

// File: rtl/chain_dma_engine.sv
module chain_dma_engine
  import chain_dma_pkg::*;
#(
  parameter int SIZE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              to_card_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic              load_i,
  input  logic              poll_i,
  input  logic              swr_i,
  input  logic              card_err_i,
  output logic              set_tx_o,
  output logic              set_rx_o,
  output logic              set_nod_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              fifo_push_o,
  output logic [DATA_W-1:0] fifo_wdata_o,
  input  logic              fifo_full_i,
  output logic              fifo_pop_o,
  input  logic [DATA_W-1:0] fifo_rdata_i,
  input  logic              fifo_empty_i
);
  localparam int CNT_W = SIZE_W - 2;
  localparam logic [DATA_W-1:0] WORD_BYTES = DATA_W'(4);

  eng_state_e        state_q;
  logic [DATA_W-1:0] cur_q, ctrl_q, buf_q, link_q, data_q, next_ptr;
  logic [CNT_W-1:0]  left_q;
  logic              err_q;
  logic              xfer, done;

  chain_dma_next_ptr u_next (
    .cur_i     (cur_q),
    .base_i    (base_i),
    .link_i    (link_q),
    .ring_end_i(ctrl_q[C_RING]),
    .chained_i (ctrl_q[C_CHAIN]),
    .next_o    (next_ptr)
  );

  assign xfer = state_q inside {ST_RD, ST_PUSH, ST_POP, ST_WR};
  assign done = (state_q == ST_WB) && mem_ack_i && !ctrl_q[C_NOIRQ];

  assign set_tx_o  = done && to_card_i;
  assign set_rx_o  = done && !to_card_i;
  assign set_nod_o = (state_q == ST_D0) && mem_ack_i && !mem_rdata_i[C_OWN];

  assign mem_req_o    = state_q inside {ST_D0, ST_D1, ST_D2, ST_D3, ST_RD, ST_WR, ST_WB};
  assign mem_we_o     = state_q inside {ST_WR, ST_WB};
  assign mem_wdata_o  = (state_q == ST_WB) ? {1'b0, err_q, ctrl_q[C_ERR-1:0]} : data_q;
  assign fifo_push_o  = (state_q == ST_PUSH) && !fifo_full_i;
  assign fifo_pop_o   = (state_q == ST_POP) && !fifo_empty_i;
  assign fifo_wdata_o = data_q;

  always_comb begin
    unique case (state_q)
      ST_D1:        mem_addr_o = cur_q + DATA_W'(4);
      ST_D2:        mem_addr_o = cur_q + DATA_W'(8);
      ST_D3:        mem_addr_o = cur_q + DATA_W'(12);
      ST_RD, ST_WR: mem_addr_o = buf_q;
      default:      mem_addr_o = cur_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      ctrl_q  <= '0;
      buf_q   <= '0;
      link_q  <= '0;
      data_q  <= '0;
      left_q  <= '0;
      err_q   <= 1'b0;
    end else if (swr_i) begin
      state_q <= ST_IDLE;
      cur_q   <= base_i;
    end else begin
      if (load_i) cur_q <= base_i;
      if (card_err_i && xfer) err_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: if (poll_i && enable_i) state_q <= ST_D0;
        ST_D0: if (mem_ack_i) begin
          ctrl_q  <= mem_rdata_i;
          err_q   <= 1'b0;
          state_q <= mem_rdata_i[C_OWN] ? ST_D1 : ST_IDLE;
        end
        ST_D1: if (mem_ack_i) begin
          left_q  <= mem_rdata_i[SIZE_W-1:2];
          state_q <= ST_D2;
        end
        ST_D2: if (mem_ack_i) begin
          buf_q   <= mem_rdata_i;
          state_q <= ST_D3;
        end
        ST_D3: if (mem_ack_i) begin
          link_q  <= mem_rdata_i;
          if (left_q == '0)   state_q <= ST_WB;
          else if (to_card_i) state_q <= ST_RD;
          else                state_q <= ST_POP;
        end
        ST_RD: if (mem_ack_i) begin
          data_q  <= mem_rdata_i;
          state_q <= ST_PUSH;
        end
        ST_PUSH: if (!fifo_full_i) begin
          buf_q   <= buf_q + WORD_BYTES;
          left_q  <= left_q - 1'b1;
          state_q <= (left_q == CNT_W'(1)) ? ST_WB : ST_RD;
        end
        ST_POP: if (!fifo_empty_i) begin
          data_q  <= fifo_rdata_i;
          state_q <= ST_WR;
        end
        ST_WR: if (mem_ack_i) begin
          buf_q   <= buf_q + WORD_BYTES;
          left_q  <= left_q - 1'b1;
          state_q <= (left_q == CNT_W'(1)) ? ST_WB : ST_POP;
        end
        ST_WB: if (mem_ack_i) begin
          cur_q   <= next_ptr;
          state_q <= (ctrl_q[C_LAST] || !enable_i) ? ST_IDLE : ST_D0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_swr_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swr_i |=> (!mem_req_o && !fifo_push_o && !fifo_pop_o));
  assert_unowned_stops_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_nod_o |=> !mem_req_o);
  assert_push_spaced_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_push_o |=> !fifo_push_o);
  assert_pop_spaced_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |=> !fifo_pop_o);
endmodule

// File: rtl/chain_dma.sv
module chain_dma
  import chain_dma_pkg::*;
#(
  parameter int SIZE_W = 12
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [3:0]  sts_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic        mem_ack_i,
  input  logic [31:0] mem_rdata_i,
  output logic        fifo_push_o,
  output logic [31:0] fifo_wdata_o,
  input  logic        fifo_full_i,
  output logic        fifo_pop_o,
  input  logic [31:0] fifo_rdata_i,
  input  logic        fifo_empty_i,
  input  logic        card_err_i
);
  logic enable, to_card, load, poll, swr, set_tx, set_rx, set_nod;
  logic [DATA_W-1:0] base;

  chain_dma_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .set_tx_i   (set_tx),
    .set_rx_i   (set_rx),
    .set_nod_i  (set_nod),
    .enable_o   (enable),
    .to_card_o  (to_card),
    .base_o     (base),
    .load_o     (load),
    .poll_o     (poll),
    .swr_o      (swr),
    .sts_o      (sts_o)
  );

  chain_dma_engine #(.SIZE_W(SIZE_W)) u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable),
    .to_card_i   (to_card),
    .base_i      (base),
    .load_i      (load),
    .poll_i      (poll),
    .swr_i       (swr),
    .card_err_i  (card_err_i),
    .set_tx_o    (set_tx),
    .set_rx_o    (set_rx),
    .set_nod_o   (set_nod),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .fifo_push_o (fifo_push_o),
    .fifo_wdata_o(fifo_wdata_o),
    .fifo_full_i (fifo_full_i),
    .fifo_pop_o  (fifo_pop_o),
    .fifo_rdata_i(fifo_rdata_i),
    .fifo_empty_i(fifo_empty_i)
  );
endmodule

// File: tb/test_chain_dma.sv
`timescale 1ns/1ps
module test_chain_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  sts;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        push, pop, full, empty, card_err;
  logic [31:0] push_data, pop_data;

  logic [31:0] mem [256];
  logic [31:0] txbuf [64];
  logic [31:0] rxsrc [4];
  int txn, rxn, rxcnt;
  logic rx_hold;
  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  chain_dma i_chain_dma (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .sts_o(sts), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata), .fifo_push_o(push), .fifo_wdata_o(push_data),
    .fifo_full_i(full), .fifo_pop_o(pop), .fifo_rdata_i(pop_data),
    .fifo_empty_i(empty), .card_err_i(card_err)
  );

  // memory model: acknowledge one cycle after request
  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[9:2]];
    end else mem_ack <= 1'b0;
  end

  always @(posedge clk) begin
    if (push) begin txbuf[txn] <= push_data; txn <= txn + 1; end
    if (pop) rxn <= rxn + 1;
  end
  assign pop_data = rxsrc[rxn[1:0]];
  assign empty = rx_hold || (rxn >= rxcnt);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] rd(input int a);
    return mem[a[9:2]];
  endfunction

  task automatic put(input int a, input logic [31:0] d);
    mem[a[9:2]] = d;
  endtask

  task automatic t_reset;
    wait_cyc(3);
    chk(sts == 4'h0, "R1 status", {28'h0, sts}, 32'h0);
    chk(!mem_req && !push && !pop, "R1 idle ports", {29'h0, mem_req, push, pop}, 32'h0);
  endtask

  // chained pair towards the card, FIFO full at first
  task automatic t_tx_chain;
    put(32'h100, 32'h8000_001A); put(32'h104, 8);  put(32'h108, 32'h200); put(32'h10C, 32'h140);
    put(32'h140, 32'h8000_0004); put(32'h144, 12); put(32'h148, 32'h280); put(32'h14C, 32'h0);
    put(32'h200, 32'h11); put(32'h204, 32'h22);
    put(32'h280, 32'h33); put(32'h284, 32'h44); put(32'h288, 32'h55);
    full = 1'b1;
    wr(2'd0, 32'h6); wr(2'd1, 32'h100); wr(2'd2, 32'h0);
    wait_cyc(40);
    chk(txn == 0, "R4 no push while full", txn, 0);
    full = 1'b0;
    wait_cyc(100);
    chk(txn == 5, "R4 word count", txn, 5);
    for (int i = 0; i < 5; i++)
      chk(txbuf[i] == 32'h11 * (i + 1), "R4 R8 word order", txbuf[i], 32'h11 * (i + 1));
    chk(rd(32'h100) == 32'h0000_001A, "R6 writeback first", rd(32'h100), 32'h0000_001A);
    chk(rd(32'h140) == 32'h0000_0004, "R6 writeback last", rd(32'h140), 32'h0000_0004);
    chk(sts == 4'h5, "R7 R9 tx done", {28'h0, sts}, 32'h5);
  endtask

  task automatic t_w1c;
    wr(2'd3, 32'h1);
    chk(sts == 4'h4, "R10 partial clear", {28'h0, sts}, 32'h4);
    wr(2'd3, 32'h4);
    chk(sts == 4'h0, "R10 full clear", {28'h0, sts}, 32'h0);
  endtask

  task automatic t_rx;
    put(32'h180, 32'h8000_0004); put(32'h184, 8); put(32'h188, 32'h300); put(32'h18C, 32'h0);
    rxsrc[0] = 32'hA1; rxsrc[1] = 32'hB2; rxcnt = 2; rx_hold = 1'b1; card_err = 1'b1;
    wr(2'd0, 32'h2); wr(2'd1, 32'h180); wr(2'd2, 32'h0);
    wait_cyc(30);
    chk(rxn == 0, "R5 no pop while empty", rxn, 0);
    rx_hold = 1'b0;
    wait_cyc(60);
    card_err = 1'b0;
    chk(rxn == 2, "R5 pop count", rxn, 2);
    chk(rd(32'h300) == 32'hA1, "R5 first word", rd(32'h300), 32'hA1);
    chk(rd(32'h304) == 32'hB2, "R5 second word", rd(32'h304), 32'hB2);
    chk(rd(32'h180) == 32'h4000_0004, "R6 error writeback", rd(32'h180), 32'h4000_0004);
    chk(sts == 4'h6, "R7 rx done", {28'h0, sts}, 32'h6);
    wr(2'd3, 32'h6);
  endtask

  // pointer now at 0x190 (plus 16), which holds an unowned word
  task automatic t_unowned;
    wr(2'd0, 32'h6); wr(2'd2, 32'h0);
    wait_cyc(30);
    chk(sts == 4'h8, "R3 no descriptor", {28'h0, sts}, 32'h8);
    chk(txn == 5 && rxn == 2, "R3 no data moved", txn, 5);
    wr(2'd0, 32'h4); wr(2'd2, 32'h0);
    chk(sts == 4'h0, "R3 poll clears", {28'h0, sts}, 32'h0);
    wait_cyc(40);
    chk(sts == 4'h0 && !mem_req, "R12 poll ignored when disabled", {28'h0, sts}, 32'h0);
    chk(txn == 5, "R12 no data when disabled", txn, 5);
  endtask

  // end of ring wins over word 3, interrupt suppressed
  task automatic t_ring;
    put(32'h1C0, 32'h8000_0022); put(32'h1C4, 4); put(32'h1C8, 32'h220); put(32'h1CC, 32'h1E0);
    put(32'h1E0, 32'h8000_0004); put(32'h1E4, 4); put(32'h1E8, 32'h240); put(32'h1EC, 32'h0);
    put(32'h220, 32'h66); put(32'h240, 32'h77);
    wr(2'd0, 32'h6); wr(2'd1, 32'h1C0); wr(2'd2, 32'h0);
    wait_cyc(80);
    chk(txn == 6 && txbuf[5] == 32'h66, "R8 R9 single word", txn, 6);
    chk(rd(32'h1E0) == 32'h8000_0004, "R8 word3 not followed", rd(32'h1E0), 32'h8000_0004);
    chk(sts == 4'h8, "R7 suppressed then wrap unowned", {28'h0, sts}, 32'h8);
    wr(2'd3, 32'h8);
  endtask

  task automatic t_swr;
    put(32'h3C0, 32'h8000_0004); put(32'h3C4, 32); put(32'h3C8, 32'h380); put(32'h3CC, 32'h0);
    for (int i = 0; i < 8; i++) put(32'h380 + 4 * i, 32'h100 + i);
    full = 1'b1;
    wr(2'd0, 32'h6); wr(2'd1, 32'h3C0); wr(2'd2, 32'h0);
    wait_cyc(30);
    wr(2'd0, 32'h7);
    full = 1'b0;
    wait_cyc(40);
    chk(txn == 6, "R11 no push after reset", txn, 6);
    chk(rd(32'h3C0) == 32'h8000_0004, "R11 no writeback", rd(32'h3C0), 32'h8000_0004);
    chk(sts == 4'h0, "R11 no status", {28'h0, sts}, 32'h0);
    wr(2'd2, 32'h0);
    wait_cyc(120);
    chk(txn == 14 && txbuf[13] == 32'h107, "R11 R2 restart from base", txbuf[13], 32'h107);
    chk(rd(32'h3C0) == 32'h0000_0004, "R11 writeback after restart", rd(32'h3C0), 32'h4);
    wr(2'd3, 32'h7);
  endtask

  task automatic t_disable_mid;
    put(32'h000, 32'h8000_0010); put(32'h004, 64); put(32'h008, 32'h0C0); put(32'h00C, 32'h020);
    put(32'h020, 32'h8000_0004); put(32'h024, 4);  put(32'h028, 32'h0C0); put(32'h02C, 32'h0);
    full = 1'b1;
    wr(2'd0, 32'h6); wr(2'd1, 32'h0); wr(2'd2, 32'h0);
    wait_cyc(30);
    wr(2'd0, 32'h4);
    full = 1'b0;
    wait_cyc(150);
    chk(txn == 30, "R12 current finishes", txn, 30);
    chk(rd(32'h000) == 32'h0000_0010, "R12 current written back", rd(32'h000), 32'h10);
    chk(rd(32'h020) == 32'h8000_0004, "R12 next not fetched", rd(32'h020), 32'h8000_0004);
    chk(sts == 4'h5, "R7 done without suppress", {28'h0, sts}, 32'h5);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    txn = 0; rxn = 0; rxcnt = 0; rx_hold = 1'b0;
    full = 1'b0; card_err = 1'b0;
    wait_cyc(2);
    rst_n = 1'b1;
    t_reset();
    t_tx_chain();
    t_w1c();
    t_rx();
    t_unowned();
    t_ring();
    t_swr();
    t_disable_mid();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule